// File: doc/BRIEF.md
# Shared-Timer Input Debounce Filter

This block cleans up a bank of up to 32 input pins that have already been brought into the clock domain. Three period registers hold cycle counts and are shared by the whole bank. Each pin chooses one of these registers, or none, with a 2-bit index. The two bits of that index sit in two separate pin-wide select registers, at the same bit position as the pin. A pin with index zero passes its raw level straight through. A pin with a non-zero index shows a new level only after the raw input has held that level for the chosen number of cycles. The filtered pins feed the data and interrupt logic that follow.

Both inputs are sampled every cycle and there is no valid/ready handshake. Raw pins are levels, and a level cannot be held back. A register write is accepted in the cycle it is presented, so neither interface has back-pressure. The period values in cycles are worked out by software and written in already rounded up. Pins that are not input-capable, as given by a parameter mask, are never filtered.

Top module: `dbc_bank_filter`

## Requirements
- R1: After reset, every period and select register is zero, so every pin output equals its raw input.
- R2: A pin whose effective index is 0 drives its raw input to its output in the same cycle, without passing through a register.
- R3: A pin's index is {high-select bit p, low-select bit p}. Write address 4 loads the high-select register and address 5 loads the low-select register. Addresses 1, 2 and 3 load the periods of timers 1, 2 and 3 from the low CW bits of the write data. A write takes effect from the clock edge that accepts it.
- R4: When a pin has a stable non-zero index and period N ≥ 1, its output takes the raw value at the N-th consecutive rising edge at which the raw input differs from the output.
- R5: A raw excursion that lasts fewer than N edges leaves the output unchanged. When the raw input returns to the output value, the count restarts from zero.
- R6: A period of 0 behaves like a period of 1: the output follows a differing raw level at the first edge.
- R7: Every pin that selects the same timer uses that timer's current period, so rewriting one period register retimes all of them.
- R8: A new period value is used at the first edge after the write. If the count already reached meets the new period, the output changes at that edge.
- R9: At the first edge after a pin's index changes, that pin's count is cleared and its output is held, so a partly counted period cannot complete against the new timer.
- R10: Pins outside the INPUT_MASK parameter always pass through, whatever their select bits hold.
- R11: A write to address 0, 6 or 7 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bank clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_raw | input | NPINS | Synchronized raw pin levels |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register write address |
| cfg_wdata | input | DW | Register write data |
| pin_filt | output | NPINS | Filtered pin levels |

## Verification
The bench goes after the edges around the count limit:
- It checks pins at period minus one and at the period itself on three timers at once. A design that is off by one would flip a cycle early or late.
- It sends a glitch one edge short of the period, followed by a fresh run. A design that does not clear its count on a return to the output level would flip during the second run.
- It shortens a period in the middle of a count and switches a pin's timer in the middle of a count. A design that latches the period at the start of a count would miss the first case. A design that does not clear the count on a timer switch would flip one edge after the switch.
- It drives pins outside the input mask and writes to unmapped addresses. Filtering those pins, or letting those writes land, shows up as a delayed output or a changed filter time.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned SEL_W      = 2;
  localparam int unsigned NUM_TIMERS = 3;
  localparam int unsigned ADDR_W     = 3;

  // write address map: timers 1..3 sit at addresses 1..3
  localparam logic [ADDR_W-1:0] ADDR_PER_BASE = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_SEL_HI   = 3'd4;
  localparam logic [ADDR_W-1:0] ADDR_SEL_LO   = 3'd5;

  typedef logic [SEL_W-1:0] tsel_t;
endpackage

// File: rtl/dbc_cfg_regs.sv
module dbc_cfg_regs
  import dbc_pkg::*;
#(
  parameter int unsigned NPINS = 32,
  parameter int unsigned CW    = 32,
  parameter int unsigned DW    = 32
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             we,
  input  logic [ADDR_W-1:0]                addr,
  input  logic [DW-1:0]                    wdata,
  output logic [NPINS-1:0]                 sel_hi,
  output logic [NPINS-1:0]                 sel_lo,
  output logic [NUM_TIMERS-1:0][CW-1:0]    periods
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_hi  <= '0;
      sel_lo  <= '0;
      periods <= '0;
    end else if (we) begin
      if (addr == ADDR_SEL_HI) sel_hi <= wdata[NPINS-1:0];
      if (addr == ADDR_SEL_LO) sel_lo <= wdata[NPINS-1:0];
      for (int t = 0; t < int'(NUM_TIMERS); t++) begin
        if (addr == ADDR_W'(int'(ADDR_PER_BASE) + t)) periods[t] <= wdata[CW-1:0];
      end
    end
  end

endmodule

// File: rtl/dbc_pin_filter.sv
module dbc_pin_filter
  import dbc_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          raw,
  input  tsel_t                         sel,
  input  logic [NUM_TIMERS-1:0][CW-1:0] periods,
  output logic                          filt
);

  logic        flt_q;
  logic [CW-1:0] cnt_q;
  tsel_t       prev_q;
  logic [CW-1:0] per;
  logic [CW:0] lim;
  logic [CW:0] nxt;
  logic        qualify;

  always_comb begin
    per = '0;
    for (int t = 0; t < int'(NUM_TIMERS); t++) begin
      if (sel == SEL_W'(t + 1)) per = periods[t];
    end
  end

  // zero period is treated as one: a single edge qualifies
  assign lim     = (per == '0) ? (CW+1)'(1) : {1'b0, per};
  assign nxt     = {1'b0, cnt_q} + (CW+1)'(1);
  assign qualify = (nxt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flt_q  <= 1'b0;
      cnt_q  <= '0;
      prev_q <= '0;
    end else begin
      prev_q <= sel;
      if (sel == '0) begin
        flt_q <= raw;
        cnt_q <= '0;
      end else if (sel != prev_q) begin
        cnt_q <= '0;
      end else if (raw == flt_q) begin
        cnt_q <= '0;
      end else if (qualify) begin
        flt_q <= raw;
        cnt_q <= '0;
      end else begin
        cnt_q <= nxt[CW-1:0];
      end
    end
  end

  assign filt = (sel == '0) ? raw : flt_q;

endmodule

// File: rtl/dbc_bank_filter.sv
module dbc_bank_filter
  import dbc_pkg::*;
#(
  parameter int unsigned     NPINS      = 32,
  parameter int unsigned     CW         = 32,
  parameter int unsigned     DW         = 32,
  parameter logic [NPINS-1:0] INPUT_MASK = '1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_raw,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  output logic [NPINS-1:0]  pin_filt
);

  logic [NPINS-1:0]              sel_hi_q;
  logic [NPINS-1:0]              sel_lo_q;
  logic [NUM_TIMERS-1:0][CW-1:0] period_q;

  dbc_cfg_regs #(
    .NPINS(NPINS),
    .CW   (CW),
    .DW   (DW)
  ) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (cfg_we),
    .addr   (cfg_addr),
    .wdata  (cfg_wdata),
    .sel_hi (sel_hi_q),
    .sel_lo (sel_lo_q),
    .periods(period_q)
  );

  for (genvar p = 0; p < int'(NPINS); p++) begin : g_pin
    tsel_t eff_sel;
    if (INPUT_MASK[p]) begin : g_in
      assign eff_sel = {sel_hi_q[p], sel_lo_q[p]};
    end else begin : g_out_only
      assign eff_sel = '0;
    end

    dbc_pin_filter #(
      .CW(CW)
    ) u_flt (
      .clk    (clk),
      .rst_n  (rst_n),
      .raw    (pin_raw[p]),
      .sel    (eff_sel),
      .periods(period_q),
      .filt   (pin_filt[p])
    );
  end

endmodule

// File: rtl/dbc_bank_filter_chk.sv
module dbc_bank_filter_chk
  import dbc_pkg::*;
#(
  parameter int unsigned      NPINS      = 32,
  parameter int unsigned      CW         = 32,
  parameter logic [NPINS-1:0] INPUT_MASK = '1
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [NPINS-1:0]              pin_raw,
  input logic [NPINS-1:0]              pin_filt,
  input logic [NPINS-1:0]              sel_hi_q,
  input logic [NPINS-1:0]              sel_lo_q,
  input logic [NUM_TIMERS-1:0][CW-1:0] period_q
);

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  for (genvar p = 0; p < int'(NPINS); p++) begin : g_pin
    tsel_t         idx;
    logic [CW-1:0] per;

    assign idx = INPUT_MASK[p] ? {sel_hi_q[p], sel_lo_q[p]} : '0;

    always_comb begin
      per = '0;
      for (int t = 0; t < int'(NUM_TIMERS); t++) begin
        if (idx == SEL_W'(t + 1)) per = period_q[t];
      end
    end

    a_r2_bypass_same_cycle: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (idx == '0) |-> (pin_filt[p] == pin_raw[p]));

    a_r4_change_takes_raw: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (idx != '0 && idx == $past(idx) && pin_filt[p] != $past(pin_filt[p]))
        |-> (pin_filt[p] == $past(pin_raw[p])));

    a_r6_short_period_one_edge: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (idx != '0 && idx == $past(idx) && per <= CW'(1) && pin_raw[p] != pin_filt[p])
        |=> (!$stable(idx) || pin_filt[p] == $past(pin_raw[p])));

    a_r9_switch_holds_output: assert property (@(posedge clk) disable iff (!rst_n || !armed)
      (idx != '0 && idx != $past(idx))
        |=> (!$stable(idx) || pin_filt[p] == $past(pin_filt[p])));

    if (!INPUT_MASK[p]) begin : g_noin
      a_r10_masked_passthrough: assert property (@(posedge clk) disable iff (!rst_n || !armed)
        pin_filt[p] == pin_raw[p]);
    end
  end

endmodule

bind dbc_bank_filter dbc_bank_filter_chk #(
  .NPINS     (NPINS),
  .CW        (CW),
  .INPUT_MASK(INPUT_MASK)
) u_chk (.*);

// File: tb/dbc_bank_filter_bench.sv
module dbc_bank_filter_bench;
  localparam logic [31:0] MASK = 32'h0FFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_raw = '0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] pin_filt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dbc_bank_filter #(
    .NPINS(32), .CW(32), .DW(32), .INPUT_MASK(MASK)
  ) u_dbc_bank_filter (
    .clk(clk), .rst_n(rst_n), .pin_raw(pin_raw), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pin_filt(pin_filt)
  );

  // behavioural reference
  longint      m_per [3];
  logic [31:0] m_hi, m_lo;
  logic        m_flt [32];
  longint      m_cnt [32];
  int          m_prev[32];

  function automatic int midx(int p);
    if (!MASK[p]) return 0;
    return {30'd0, m_hi[p], m_lo[p]};
  endfunction

  function automatic logic [31:0] mout();
    logic [31:0] v;
    for (int p = 0; p < 32; p++) v[p] = (midx(p) == 0) ? pin_raw[p] : m_flt[p];
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_hi = '0; m_lo = '0;
      for (int t = 0; t < 3; t++) m_per[t] = 0;
      for (int p = 0; p < 32; p++) begin m_flt[p] = 0; m_cnt[p] = 0; m_prev[p] = 0; end
    end else begin
      for (int p = 0; p < 32; p++) begin
        int i;
        longint lim;
        i = midx(p);
        if (i == 0) begin
          m_flt[p] = pin_raw[p]; m_cnt[p] = 0;
        end else if (i != m_prev[p]) begin
          m_cnt[p] = 0;
        end else if (pin_raw[p] == m_flt[p]) begin
          m_cnt[p] = 0;
        end else begin
          lim = (m_per[i-1] == 0) ? 1 : m_per[i-1];
          if (m_cnt[p] + 1 >= lim) begin m_flt[p] = pin_raw[p]; m_cnt[p] = 0; end
          else m_cnt[p] = m_cnt[p] + 1;
        end
        m_prev[p] = i;
      end
      if (cfg_we) begin
        case (cfg_addr)
          3'd1: m_per[0] = longint'(cfg_wdata);
          3'd2: m_per[1] = longint'(cfg_wdata);
          3'd3: m_per[2] = longint'(cfg_wdata);
          3'd4: m_hi = cfg_wdata;
          3'd5: m_lo = cfg_wdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pin_filt !== mout()) begin
        errors++;
        $display("FAIL R4 cycle model got=%h exp=%h", pin_filt, mout());
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); #1; endtask
  task automatic settle(); @(negedge clk); endtask
  task automatic ticks(input int n); for (int i = 0; i < n; i++) tick(); endtask
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick();
    cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
  endtask

  logic [31:0] hi_v, lo_v;

  initial begin
    // R1 reset state
    pin_raw = 32'hA5A5_0F0F;
    ticks(3); settle();
    chk("R1 reset passthrough", pin_filt, 32'hA5A5_0F0F);
    tick(); rst_n = 1'b1; pin_raw = '0;
    ticks(2);
    // R2 same-cycle bypass
    pin_raw = 32'h1234_5678; settle();
    chk("R2 bypass same cycle", pin_filt, 32'h1234_5678);
    tick(); pin_raw = '0; tick();
    // R3 map, R4 qualification length
    wr(3'd1, 32'd4); wr(3'd2, 32'd2); wr(3'd3, 32'd6);
    hi_v = 32'h6; lo_v = 32'h5;
    wr(3'd4, hi_v); wr(3'd5, lo_v);
    ticks(2);
    pin_raw[2:0] = 3'b111;
    for (int k = 1; k <= 6; k++) begin
      tick(); settle();
      chk("R4 pin0 timer1 len4", {31'd0, pin_filt[0]}, {31'd0, k >= 4});
      chk("R3 pin1 timer2 len2", {31'd0, pin_filt[1]}, {31'd0, k >= 2});
      chk("R3 pin2 timer3 len6", {31'd0, pin_filt[2]}, {31'd0, k >= 6});
    end
    // R5 glitch one short, then restart
    pin_raw[0] = 1'b0; ticks(3); pin_raw[0] = 1'b1; tick(); settle();
    chk("R5 short glitch ignored", {31'd0, pin_filt[0]}, 32'd1);
    pin_raw[0] = 1'b0; ticks(3); settle();
    chk("R5 count restarted", {31'd0, pin_filt[0]}, 32'd1);
    tick(); settle();
    chk("R5 full run flips", {31'd0, pin_filt[0]}, 32'd0);
    // R6 period 0 and 1
    wr(3'd1, 32'd0);
    pin_raw[0] = 1'b1; settle();
    chk("R6 registered, not bypass", {31'd0, pin_filt[0]}, 32'd0);
    tick(); settle();
    chk("R6 period0 one edge", {31'd0, pin_filt[0]}, 32'd1);
    wr(3'd1, 32'd1);
    pin_raw[0] = 1'b0; settle();
    chk("R6 registered, not bypass", {31'd0, pin_filt[0]}, 32'd1);
    tick(); settle();
    chk("R6 period1 one edge", {31'd0, pin_filt[0]}, 32'd0);
    // R7 shared timer
    lo_v = lo_v | 32'h18; wr(3'd5, lo_v); wr(3'd1, 32'd3); ticks(2);
    pin_raw[4:3] = 2'b11; ticks(2); settle();
    chk("R7 shared len3 early", {30'd0, pin_filt[4:3]}, 32'd0);
    tick(); settle();
    chk("R7 shared len3 both", {30'd0, pin_filt[4:3]}, 32'd3);
    wr(3'd1, 32'd5);
    pin_raw[4:3] = 2'b00; ticks(4); settle();
    chk("R7 retimed len5 early", {30'd0, pin_filt[4:3]}, 32'd3);
    tick(); settle();
    chk("R7 retimed len5 both", {30'd0, pin_filt[4:3]}, 32'd0);
    // R8 period lowered mid-count
    wr(3'd1, 32'd8);
    pin_raw[0] = 1'b1; ticks(4); wr(3'd1, 32'd2); settle();
    chk("R8 not yet", {31'd0, pin_filt[0]}, 32'd0);
    tick(); settle();
    chk("R8 new period at next edge", {31'd0, pin_filt[0]}, 32'd1);
    // R9 selector switch clears count
    wr(3'd1, 32'd8); wr(3'd3, 32'd2);
    pin_raw[0] = 1'b0; ticks(2);
    hi_v = hi_v | 32'h1; wr(3'd4, hi_v); settle();
    chk("R9 before switch edge", {31'd0, pin_filt[0]}, 32'd1);
    tick(); settle();
    chk("R9 switch edge holds", {31'd0, pin_filt[0]}, 32'd1);
    tick(); settle();
    chk("R9 recount 1 of 2", {31'd0, pin_filt[0]}, 32'd1);
    tick(); settle();
    chk("R9 recount done", {31'd0, pin_filt[0]}, 32'd0);
    // R10 non-input pin
    hi_v = hi_v | 32'h8000_0000; lo_v = lo_v | 32'h8000_0000;
    wr(3'd4, hi_v); wr(3'd5, lo_v);
    pin_raw[31] = 1'b1; settle();
    chk("R10 masked pin passthrough", {31'd0, pin_filt[31]}, 32'd1);
    tick(); pin_raw[31] = 1'b0; settle();
    chk("R10 masked pin passthrough", {31'd0, pin_filt[31]}, 32'd0);
    // R11 unmapped writes
    wr(3'd0, '1); wr(3'd6, '1); wr(3'd7, '1);
    pin_raw[5] = 1'b1; settle();
    chk("R11 pin5 still bypass", {31'd0, pin_filt[5]}, 32'd1);
    tick(); pin_raw[5] = 1'b0;
    pin_raw[1] = 1'b0; tick(); settle();
    chk("R11 timer2 len kept early", {31'd0, pin_filt[1]}, 32'd1);
    tick(); settle();
    chk("R11 timer2 len kept", {31'd0, pin_filt[1]}, 32'd0);
    // sparse random toggles against the model
    for (int c = 0; c < 400; c++) begin
      pin_raw = pin_raw ^ ($urandom & $urandom & $urandom);
      tick();
    end
    settle();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL R4 watchdog got=running exp=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule